// File: doc/BRIEF.md
# Two-Wire Register Target with Strap-Selected Address

This block is a two-wire serial target that lets a host read and write a local register space. Each access carries a 16-bit register address, sent as two bytes with the high byte first. During a burst the address steps up by one after every data byte. A read begins the same way as a write: the host sends the register address, then a repeated START and the device address with the read bit set. The target then returns bytes until the host answers with a NACK.

The 7-bit device address comes from two strap pins through a fixed table of four values. An override register sits inside the block at a parameterised register address. When bit 7 of that register is set, its lower seven bits become the device address. The device address is captured at each START condition.

SDA and SCL are handled as open-drain lines: the block only ever pulls them low. On the core side, register accesses go out on a simple request/done bus. When clock stretching is enabled, SCL is held low while an access is outstanding. When stretching is disabled, SCL is never held and each completion is reported as an interrupt pulse.

Top module: `i2c_reg_target`

## Requirements
- R1: The strap code selects the device address. Bit 1 of `strap_i` is the high bit. Code 0 selects 0x0B, 1 selects 0x34, 2 selects 0x77 and 3 selects 0x65. A matching address byte is ACKed by driving SDA low in the ninth clock.
- R2: The override register sits at register address 0x0030. Its reset value is 0x00, and it can be read back over the bus. When bit 7 is 1, bits [6:0] become the device address and the strap address no longer matches. Writing bit 7 as 0 brings the strap address back.
- R3: A write to the override register does not change the address inside the transaction in progress. The data byte that follows in the same burst is still ACKed and goes to the next register address.
- R4: A write transaction is: device address with W=0, register address high byte, register address low byte, then one or more data bytes. Every byte is ACKed. Every data byte outside the override address produces one single-cycle `reg_req_o` with `reg_we_o`=1. The request carries the current address, which is then incremented.
- R5: After a repeated START and the device address with R=1, the target returns register data MSB first. Each byte comes from one read request. The address increments after each request. After a NACK no further read request is issued.
- R6: An address byte that does not match is not ACKed. It causes no register access, and the target ignores the bus until the next START.
- R7: With `stretch_en_i`=1, SCL is held low from the moment an access is issued until `reg_done_i` returns.
- R8: With `stretch_en_i`=0, SCL is never held low, and `done_irq_o` pulses once for each completed access.
- R9: A STOP returns the target to idle with SDA released. A START in the middle of a byte abandons that transaction, and the transaction that follows works normally.
- R10: After reset, SCL and SDA are released and no request is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_oe_o | output | 1 | 1 pulls SCL low |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| strap_i | input | 2 | Device-address strap code |
| stretch_en_i | input | 1 | 1 enables clock stretching |
| reg_req_o | output | 1 | Register access request pulse |
| reg_we_o | output | 1 | 1 for write, 0 for read |
| reg_addr_o | output | 16 | Register address of the request |
| reg_wdata_o | output | 8 | Write data |
| reg_rdata_i | input | 8 | Read data, valid with reg_done_i |
| reg_done_i | input | 1 | Access completion pulse |
| done_irq_o | output | 1 | Completion pulse when stretching is off |

## Verification
The bench uses the default parameters: a two-flop synchroniser and the override register at 0x0030. With these values, every address the strap pins can select is exercised, and the override register can be reached, read back and reprogrammed in the middle of a burst. The register bus model in the bench has a programmable completion latency. At two cycles, the non-stretching path completes well inside one SCL half-period. At thirty cycles, the bus access takes longer than that half-period, so the stretch hold actually delays the host.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned REG_AW = 2 * BYTE_W;
  localparam int unsigned DEV_AW = 7;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RX, ST_RX_ACK, ST_TX, ST_TX_ACK
  } tgt_st_e;

  typedef enum logic [1:0] {
    PH_DEV, PH_AHI, PH_ALO, PH_DAT
  } tgt_ph_e;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s_o,
  output logic sda_s_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [1:0] pipe_q [STAGES];
  logic       scl_d_q, sda_d_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) pipe_q[g] <= 2'b11;
        else         pipe_q[g] <= {scl_i, sda_i};
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) pipe_q[g] <= 2'b11;
        else         pipe_q[g] <= pipe_q[g-1];
    end
  end

  assign scl_s_o = pipe_q[STAGES-1][1];
  assign sda_s_o = pipe_q[STAGES-1][0];

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      scl_d_q <= 1'b1;
      sda_d_q <= 1'b1;
    end else begin
      scl_d_q <= scl_s_o;
      sda_d_q <= sda_s_o;
    end

  assign scl_rise_o = scl_s_o & ~scl_d_q;
  assign scl_fall_o = ~scl_s_o & scl_d_q;
  // SDA edge while SCL stays high
  assign start_o = scl_s_o & scl_d_q & sda_d_q & ~sda_s_o;
  assign stop_o  = scl_s_o & scl_d_q & ~sda_d_q & sda_s_o;
endmodule

// File: rtl/i2c_addr_sel.sv
module i2c_addr_sel
  import i2c_tgt_pkg::*;
(
  input  logic [1:0]        strap_i,
  input  logic [BYTE_W-1:0] ovr_i,
  output logic [DEV_AW-1:0] dev_addr_o
);
  localparam logic [DEV_AW-1:0] STRAP_TBL [4] = '{7'h0B, 7'h34, 7'h77, 7'h65};

  always_comb begin
    if (ovr_i[BYTE_W-1]) dev_addr_o = ovr_i[DEV_AW-1:0];
    else                 dev_addr_o = STRAP_TBL[strap_i];
  end
endmodule

// File: rtl/i2c_tgt_fsm.sv
module i2c_tgt_fsm
  import i2c_tgt_pkg::*;
#(
  parameter logic [REG_AW-1:0] OVR_ADDR = 16'h0030
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sda_s_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic [DEV_AW-1:0] dev_addr_i,
  input  logic              stretch_en_i,
  input  logic [BYTE_W-1:0] reg_rdata_i,
  input  logic              reg_done_i,
  output logic              sda_oe_o,
  output logic              scl_oe_o,
  output logic              reg_req_o,
  output logic              reg_we_o,
  output logic [REG_AW-1:0] reg_addr_o,
  output logic [BYTE_W-1:0] reg_wdata_o,
  output logic              done_irq_o,
  output logic [BYTE_W-1:0] ovr_o
);
  localparam int unsigned CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] BITS = CNT_W'(BYTE_W);

  tgt_st_e           st_q;
  tgt_ph_e           ph_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [BYTE_W-1:0] sh_q, tx_q, ovr_q;
  logic [REG_AW-1:0] ra_q;
  logic [DEV_AW-1:0] dev_q;
  logic              rd_q, nack_q, busy_q, sda_oe_q;
  logic              rd_go;

  // next read is fetched at the falling edge that opens a transmit byte
  assign rd_go = !start_i && !stop_i && scl_fall_i &&
                 ((st_q == ST_RX_ACK && rd_q) || (st_q == ST_TX_ACK && !nack_q));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_IDLE;  ph_q <= PH_DEV;  cnt_q <= '0;
      sh_q <= '0;  tx_q <= '0;  ovr_q <= '0;  ra_q <= '0;  dev_q <= '0;
      rd_q <= 1'b0;  nack_q <= 1'b0;  busy_q <= 1'b0;  sda_oe_q <= 1'b0;
      reg_req_o <= 1'b0;  reg_we_o <= 1'b0;  reg_addr_o <= '0;  reg_wdata_o <= '0;
      done_irq_o <= 1'b0;
    end else begin
      reg_req_o  <= 1'b0;
      done_irq_o <= 1'b0;
      if (reg_done_i && busy_q) begin
        busy_q     <= 1'b0;
        done_irq_o <= !stretch_en_i;
        if (!reg_we_o && st_q == ST_TX) begin
          tx_q     <= reg_rdata_i;
          sda_oe_q <= ~reg_rdata_i[BYTE_W-1];
        end
      end
      if (start_i) begin
        st_q <= ST_RX;  ph_q <= PH_DEV;  cnt_q <= '0;
        sda_oe_q <= 1'b0;  dev_q <= dev_addr_i;
      end else if (stop_i) begin
        st_q <= ST_IDLE;  sda_oe_q <= 1'b0;
      end else begin
        unique case (st_q)
          ST_RX: begin
            if (scl_rise_i && cnt_q != BITS) begin
              sh_q  <= {sh_q[BYTE_W-2:0], sda_s_i};
              cnt_q <= cnt_q + 1'b1;
            end else if (scl_fall_i && cnt_q == BITS) begin
              cnt_q <= '0;
              unique case (ph_q)
                PH_DEV: begin
                  if (sh_q[BYTE_W-1:1] == dev_q) begin
                    sda_oe_q <= 1'b1;  st_q <= ST_RX_ACK;
                    rd_q <= sh_q[0];  ph_q <= PH_AHI;
                  end else begin
                    st_q <= ST_IDLE;
                  end
                end
                PH_AHI: begin
                  ra_q[REG_AW-1:BYTE_W] <= sh_q;
                  sda_oe_q <= 1'b1;  st_q <= ST_RX_ACK;  ph_q <= PH_ALO;
                end
                PH_ALO: begin
                  ra_q[BYTE_W-1:0] <= sh_q;
                  sda_oe_q <= 1'b1;  st_q <= ST_RX_ACK;  ph_q <= PH_DAT;
                end
                default: begin
                  sda_oe_q <= 1'b1;  st_q <= ST_RX_ACK;
                  ra_q <= ra_q + 1'b1;
                  if (ra_q == OVR_ADDR) ovr_q <= sh_q;
                  else begin
                    reg_req_o <= 1'b1;  reg_we_o <= 1'b1;  busy_q <= 1'b1;
                    reg_addr_o <= ra_q;  reg_wdata_o <= sh_q;
                  end
                end
              endcase
            end
          end
          ST_RX_ACK: if (scl_fall_i) begin
            sda_oe_q <= 1'b0;  cnt_q <= '0;
            st_q <= rd_q ? ST_TX : ST_RX;
          end
          ST_TX: begin
            if (scl_rise_i) cnt_q <= cnt_q + 1'b1;
            else if (scl_fall_i) begin
              if (cnt_q == BITS) begin
                sda_oe_q <= 1'b0;  st_q <= ST_TX_ACK;
              end else begin
                tx_q     <= {tx_q[BYTE_W-2:0], 1'b0};
                sda_oe_q <= ~tx_q[BYTE_W-2];
              end
            end
          end
          ST_TX_ACK: begin
            if (scl_rise_i) nack_q <= sda_s_i;
            else if (scl_fall_i) begin
              cnt_q <= '0;
              st_q  <= nack_q ? ST_IDLE : ST_TX;
            end
          end
          default: ;
        endcase
        if (rd_go) begin
          ra_q <= ra_q + 1'b1;
          if (ra_q == OVR_ADDR) begin
            tx_q <= ovr_q;  sda_oe_q <= ~ovr_q[BYTE_W-1];
          end else begin
            reg_req_o <= 1'b1;  reg_we_o <= 1'b0;  busy_q <= 1'b1;
            reg_addr_o <= ra_q;  sda_oe_q <= 1'b0;
          end
        end
      end
    end
  end

  assign sda_oe_o = sda_oe_q;
  assign scl_oe_o = busy_q & stretch_en_i;
  assign ovr_o    = ovr_q;

  // R4
  req_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_req_o |=> !reg_req_o);
  // R5
  rd_in_tx_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_req_o && !reg_we_o) |-> (st_q == ST_TX));
  // R7
  hold_until_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scl_oe_o && !reg_done_i) |=> (scl_oe_o || !stretch_en_i));
  // R8
  no_stretch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stretch_en_i |-> !scl_oe_o);
  // R9
  stop_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> !sda_oe_o);
endmodule

// File: rtl/i2c_reg_target.sv
module i2c_reg_target
  import i2c_tgt_pkg::*;
#(
  parameter logic [15:0] OVR_ADDR    = 16'h0030,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        scl_i,
  input  logic        sda_i,
  output logic        scl_oe_o,
  output logic        sda_oe_o,
  input  logic [1:0]  strap_i,
  input  logic        stretch_en_i,
  output logic        reg_req_o,
  output logic        reg_we_o,
  output logic [15:0] reg_addr_o,
  output logic [7:0]  reg_wdata_o,
  input  logic [7:0]  reg_rdata_i,
  input  logic        reg_done_i,
  output logic        done_irq_o
);
  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic [BYTE_W-1:0] ovr;
  logic [DEV_AW-1:0] dev_addr;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .scl_s_o(scl_s), .sda_s_o(sda_s), .scl_rise_o(scl_rise),
    .scl_fall_o(scl_fall), .start_o(start_det), .stop_o(stop_det)
  );

  i2c_addr_sel u_asel (.strap_i, .ovr_i(ovr), .dev_addr_o(dev_addr));

  i2c_tgt_fsm #(.OVR_ADDR(OVR_ADDR)) u_fsm (
    .clk_i, .rst_ni, .sda_s_i(sda_s), .scl_rise_i(scl_rise), .scl_fall_i(scl_fall),
    .start_i(start_det), .stop_i(stop_det), .dev_addr_i(dev_addr),
    .stretch_en_i, .reg_rdata_i, .reg_done_i,
    .sda_oe_o, .scl_oe_o, .reg_req_o, .reg_we_o, .reg_addr_o, .reg_wdata_o,
    .done_irq_o, .ovr_o(ovr)
  );

  // R10
  rst_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (!sda_oe_o && !scl_oe_o));

  logic unused_scl;
  assign unused_scl = scl_s;
endmodule

// File: tb/sim_i2c_reg_target.sv
module sim_i2c_reg_target;
  localparam int H = 10;

  typedef struct packed {
    logic [1:0]  strap;
    logic [15:0] ra;
    logic [7:0]  d0;
    logic [7:0]  d1;
  } vec_t;

  localparam vec_t VEC [4] = '{
    '{2'd0, 16'h1210, 8'hA5, 8'h3C},
    '{2'd1, 16'h0A55, 8'h01, 8'hFE},
    '{2'd2, 16'hFF7E, 8'h80, 8'h7F},
    '{2'd3, 16'h01C2, 8'h5A, 8'hC3}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic [1:0] strap = 2'd0;
  logic stretch = 1'b0;
  logic scl_oe, sda_oe, req, we, done_irq;
  logic [15:0] addr;
  logic [7:0] wdata;
  logic [7:0] rdata = '0;
  logic done = 1'b0;
  logic scl_w, sda_w;

  int checks = 0, fails = 0, lat = 2;
  int nreq = 0, irq_n = 0, cnt = 0;
  logic pend = 1'b0, pwe = 1'b0, saw_hold = 1'b0, finished = 1'b0;
  logic [15:0] pa = '0, last_a = '0;
  logic [7:0] pwd = '0;
  logic [7:0] mem [256];

  always #5 clk = ~clk;
  assign scl_w = m_scl & ~scl_oe;
  assign sda_w = m_sda & ~sda_oe;

  i2c_reg_target u0 (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_w), .sda_i(sda_w),
    .scl_oe_o(scl_oe), .sda_oe_o(sda_oe), .strap_i(strap), .stretch_en_i(stretch),
    .reg_req_o(req), .reg_we_o(we), .reg_addr_o(addr), .reg_wdata_o(wdata),
    .reg_rdata_i(rdata), .reg_done_i(done), .done_irq_o(done_irq)
  );

  // register bus model
  always @(posedge clk) begin
    done <= 1'b0;
    if (scl_oe) saw_hold <= 1'b1;
    if (done_irq) irq_n <= irq_n + 1;
    if (req) begin
      pend <= 1'b1; cnt <= lat; pa <= addr; pwe <= we; pwd <= wdata;
      last_a <= addr; nreq <= nreq + 1;
    end else if (pend) begin
      if (cnt == 0) begin
        done <= 1'b1; pend <= 1'b0;
        if (pwe) mem[pa[7:0]] <= pwd; else rdata <= mem[pa[7:0]];
      end else cnt <= cnt - 1;
    end
  end

  task automatic chk(input bit ok, input string r, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  function automatic logic [6:0] strap_dev(input logic [1:0] s);
    case (s)
      2'd0: return 7'h0B;
      2'd1: return 7'h34;
      2'd2: return 7'h77;
      default: return 7'h65;
    endcase
  endfunction

  task automatic half();
    repeat (H) @(negedge clk);
  endtask

  task automatic m_start();
    m_sda = 1'b1; half(); m_scl = 1'b1;
    do @(negedge clk); while (!scl_w);
    half(); m_sda = 1'b0; half(); m_scl = 1'b0; half();
  endtask

  task automatic m_stop();
    m_sda = 1'b0; half(); m_scl = 1'b1;
    do @(negedge clk); while (!scl_w);
    half(); m_sda = 1'b1; half();
  endtask

  task automatic bit_io(input logic b, output logic r);
    m_sda = b; half(); m_scl = 1'b1;
    do @(negedge clk); while (!scl_w);
    half(); r = sda_w; m_scl = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic wr_byte(input logic [7:0] d, output logic ack);
    logic r;
    for (int i = 7; i >= 0; i--) bit_io(d[i], r);
    bit_io(1'b1, ack);
  endtask

  task automatic rd_byte(input logic last, output logic [7:0] d);
    logic r;
    for (int i = 7; i >= 0; i--) begin bit_io(1'b1, r); d[i] = r; end
    bit_io(last, r);
  endtask

  task automatic wr_burst(input logic [6:0] dev, input logic [15:0] ra,
                          input logic [7:0] d0, input logic [7:0] d1, input int n,
                          output int nacks);
    logic a;
    nacks = 0;
    m_start();
    wr_byte({dev, 1'b0}, a); nacks += a;
    if (!a) begin
      wr_byte(ra[15:8], a); nacks += a;
      wr_byte(ra[7:0], a);  nacks += a;
      wr_byte(d0, a);       nacks += a;
      if (n > 1) begin wr_byte(d1, a); nacks += a; end
    end
    m_stop();
  endtask

  task automatic rd_burst(input logic [6:0] dev, input logic [15:0] ra, input int n,
                          output logic [7:0] q0, output logic [7:0] q1, output int nacks);
    logic a;
    nacks = 0; q0 = '0; q1 = '0;
    m_start();
    wr_byte({dev, 1'b0}, a); nacks += a;
    wr_byte(ra[15:8], a);    nacks += a;
    wr_byte(ra[7:0], a);     nacks += a;
    m_start();
    wr_byte({dev, 1'b1}, a); nacks += a;
    rd_byte(n == 1, q0);
    if (n > 1) rd_byte(1'b1, q1);
    m_stop();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int nk, r0;
    logic [7:0] q0, q1;
    for (int i = 0; i < 256; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(!scl_oe && !sda_oe && !req, "R10", {scl_oe, sda_oe, req}, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(!scl_oe && !sda_oe, "R10", {scl_oe, sda_oe}, 0);

    // R1 R4 R5: vector table, stretching off
    foreach (VEC[i]) begin
      strap = VEC[i].strap;
      wr_burst(strap_dev(strap), VEC[i].ra, VEC[i].d0, VEC[i].d1, 2, nk);
      chk(nk == 0, "R1", nk, 0);
      chk(mem[VEC[i].ra[7:0]] == VEC[i].d0 && mem[8'(VEC[i].ra[7:0] + 1)] == VEC[i].d1,
          "R4", mem[VEC[i].ra[7:0]], VEC[i].d0);
      chk(last_a == VEC[i].ra + 16'd1, "R4", last_a, VEC[i].ra + 16'd1);
      r0 = nreq;
      rd_burst(strap_dev(strap), VEC[i].ra, 2, q0, q1, nk);
      chk(nk == 0 && q0 == VEC[i].d0 && q1 == VEC[i].d1, "R5", {q0, q1}, {VEC[i].d0, VEC[i].d1});
      repeat (4) @(negedge clk);
      chk(nreq - r0 == 2, "R5", nreq - r0, 2);
      // R9 released after stop
      chk(!sda_oe, "R9", sda_oe, 0);
    end

    // R6 wrong address
    strap = 2'd0;
    r0 = nreq;
    wr_burst(7'h34, 16'h0010, 8'hEE, 8'h00, 1, nk);
    chk(nk == 1, "R6", nk, 1);
    chk(nreq == r0, "R6", nreq - r0, 0);

    // R8 no stretch: irq per access, no hold
    saw_hold = 1'b0; r0 = irq_n;
    wr_burst(7'h0B, 16'h0020, 8'h11, 8'h22, 2, nk);
    repeat (4) @(negedge clk);
    chk(irq_n - r0 == 2 && !saw_hold, "R8", irq_n - r0, 2);

    // R7 stretch with slow bus
    stretch = 1'b1; lat = 30; saw_hold = 1'b0; r0 = irq_n;
    wr_burst(7'h0B, 16'h0040, 8'h5A, 8'h00, 1, nk);
    rd_burst(7'h0B, 16'h0040, 1, q0, q1, nk);
    chk(q0 == 8'h5A && nk == 0, "R7", q0, 8'h5A);
    chk(saw_hold && irq_n == r0, "R7", saw_hold, 1);
    stretch = 1'b0; lat = 2;

    // R2 R3 override, written mid-burst
    wr_burst(7'h0B, 16'h0030, 8'hAA, 8'h66, 2, nk);
    chk(nk == 0 && mem[8'h31] == 8'h66 && last_a == 16'h0031, "R3", last_a, 16'h0031);
    wr_burst(7'h0B, 16'h0050, 8'h01, 8'h00, 1, nk);
    chk(nk == 1, "R2", nk, 1);
    rd_burst(7'h2A, 16'h0030, 1, q0, q1, nk);
    chk(nk == 0 && q0 == 8'hAA, "R2", q0, 8'hAA);
    wr_burst(7'h2A, 16'h0030, 8'h00, 8'h00, 1, nk);
    rd_burst(7'h0B, 16'h0030, 1, q0, q1, nk);
    chk(nk == 0 && q0 == 8'h00, "R2", q0, 0);

    // R9 start in the middle of a byte
    begin
      logic a, r;
      m_start();
      wr_byte({7'h0B, 1'b0}, a);
      for (int i = 0; i < 4; i++) bit_io(1'b1, r);
      m_start();
      wr_byte({7'h0B, 1'b0}, a); wr_byte(8'h00, a); wr_byte(8'h60, a); wr_byte(8'h99, a);
      m_stop();
      repeat (4) @(negedge clk);
      chk(!a && mem[8'h60] == 8'h99, "R9", mem[8'h60], 8'h99);
    end

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule